// File: doc/BRIEF.md
# Inverted Page Table Address Translator

This block turns an 11-bit virtual word address into a 10-bit word address inside user space. It does this with a table that has one entry for each physical page frame, not one for each virtual page. Each entry holds a valid flag, the virtual page number that now occupies the frame, and two usage flags: accessed and modified. A translation compares the page number of the request against every frame entry in parallel. When a valid entry matches, the frame index and the word offset are joined to form the physical address. When no valid entry matches, the block signals an invalid-address fault. Saving the faulting program counter and dispatching the interrupt are left to the CPU.

The request side is a valid/ready stream. The response appears in the same cycle as the request, so the block adds no latency. Back-pressure from the response side passes straight to `req_ready`. A request transfers only on a cycle where `req_valid` and `rsp_ready` are both high, and only a transferred hit updates the usage flags. This lets a stalled request be held and presented again without marking its page twice. The operating system loads entries through a plain write port and reads them back through a combinational read port. When virtual memory is off, the address passes through to user space with no lookup.

Top module: `ipt_mmu`

## Requirements
- R1: After reset every entry reads back as valid=0, page=0, accessed=0, modified=0, and a request with translation enabled is answered with a fault.
- R2: `rsp_valid` equals `req_valid` in the same cycle and `req_ready` equals `rsp_ready`. While `rsp_ready` is 0, a request still gets its combinational response, but no entry changes at the next clock edge.
- R3: With translation enabled, a request whose upper 6 address bits equal the stored page of a valid entry i gives `rsp_hit`=1, `rsp_fault`=0 and `rsp_paddr` = {i[4:0], vaddr[4:0]}.
- R4: With translation enabled, a request that matches no valid entry gives `rsp_fault`=1, `rsp_hit`=0 and `rsp_paddr`=0.
- R5: When several valid entries hold the requested page, the lowest-numbered frame is used.
- R6: A transferred read or write that hits entry i sets that entry's accessed flag. The flag reads back as 1 from the next cycle on.
- R7: A transferred write hit also sets the entry's modified flag. A read hit leaves the modified flag unchanged.
- R8: With translation disabled, an address whose bit 10 is 0 gives `rsp_hit`=1 and `rsp_paddr`=vaddr[9:0], and no entry changes. An address whose bit 10 is 1 lies outside user space and gives a fault with `rsp_paddr`=0.
- R9: An operating-system write to entry i sets all four fields of that entry from the write port. It wins over a usage-flag update to the same entry in the same cycle.
- R10: An entry whose valid flag is 0 never matches, even when its stored page equals the requested page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vm_enable | input | 1 | 1 = translate through the table, 0 = direct user-space access |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle (follows rsp_ready) |
| req_vaddr | input | 11 | Virtual word address: [10:5] page, [4:0] offset |
| req_write | input | 1 | 1 = store reference, 0 = load reference |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer accepts the response |
| rsp_paddr | output | 10 | User-space word address, 0 on fault |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_fault | output | 1 | Invalid-address fault |
| tbl_wr_en | input | 1 | Operating-system entry write strobe |
| tbl_wr_idx | input | 5 | Frame index written |
| tbl_wr_valid | input | 1 | Valid flag to store |
| tbl_wr_page | input | 6 | Virtual page number to store |
| tbl_wr_accessed | input | 1 | Accessed flag to store |
| tbl_wr_modified | input | 1 | Modified flag to store |
| tbl_rd_idx | input | 5 | Frame index read back |
| tbl_rd_valid | output | 1 | Valid flag of the entry read |
| tbl_rd_page | output | 6 | Page number of the entry read |
| tbl_rd_accessed | output | 1 | Accessed flag of the entry read |
| tbl_rd_modified | output | 1 | Modified flag of the entry read |

## Verification
The assertions assume that `rst_n` is low before the first clock edge. They also assume that request and table-write inputs change only away from the rising edge, so that a held request under back-pressure is the same request from one cycle to the next. The bench changes every input on the falling edge and keeps `rsp_ready` high apart from the one scenario that checks back-pressure. Duplicate page numbers are loaded on purpose only in the priority scenario. Elsewhere each page lives in a single frame, so the expected frame index is never in doubt.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  localparam int unsigned IPT_FRAMES = 32;
  localparam int unsigned IPT_PAGE_W = 6;
  localparam int unsigned IPT_OFF_W  = 5;

  typedef enum logic [1:0] {
    XL_FAULT  = 2'd0,
    XL_MAPPED = 2'd1,
    XL_DIRECT = 2'd2
  } xl_kind_e;
endpackage

// File: rtl/ipt_entry_store.sv
module ipt_entry_store #(
  parameter int unsigned FRAMES = 32,
  parameter int unsigned PAGE_W = 6,
  localparam int unsigned IDX_W = $clog2(FRAMES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic                           wr_valid,
  input  logic [PAGE_W-1:0]              wr_page,
  input  logic                           wr_acc,
  input  logic                           wr_mod,
  input  logic                           upd_en,
  input  logic [IDX_W-1:0]               upd_idx,
  input  logic                           upd_write,
  input  logic [IDX_W-1:0]               rd_idx,
  output logic                           rd_valid,
  output logic [PAGE_W-1:0]              rd_page,
  output logic                           rd_acc,
  output logic                           rd_mod,
  output logic [FRAMES-1:0]              val_vec,
  output logic [FRAMES-1:0][PAGE_W-1:0]  page_vec
);
  logic [FRAMES-1:0]             val_q, acc_q, mod_q;
  logic [FRAMES-1:0][PAGE_W-1:0] page_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      acc_q  <= '0;
      mod_q  <= '0;
      page_q <= '0;
    end else begin
      for (int i = 0; i < int'(FRAMES); i++) begin
        if (wr_en && wr_idx == IDX_W'(i)) begin
          val_q[i]  <= wr_valid;
          page_q[i] <= wr_page;
          acc_q[i]  <= wr_acc;
          mod_q[i]  <= wr_mod;
        end else if (upd_en && upd_idx == IDX_W'(i)) begin
          acc_q[i] <= 1'b1;
          mod_q[i] <= mod_q[i] | upd_write;
        end
      end
    end
  end

  assign val_vec  = val_q;
  assign page_vec = page_q;
  assign rd_valid = val_q[rd_idx];
  assign rd_page  = page_q[rd_idx];
  assign rd_acc   = acc_q[rd_idx];
  assign rd_mod   = mod_q[rd_idx];

  // R6: a hardware update not overridden by software marks the entry accessed
  a_r6_accessed_set: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !(wr_en && wr_idx == upd_idx)) |=> acc_q[$past(upd_idx)]);

  // R7: a store update not overridden by software marks the entry modified
  a_r7_modified_set: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_write && !(wr_en && wr_idx == upd_idx)) |=> mod_q[$past(upd_idx)]);

  // R9: a software write lands exactly, whatever else happened that cycle
  a_r9_os_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (val_q[$past(wr_idx)] == $past(wr_valid)) &&
              (page_q[$past(wr_idx)] == $past(wr_page)) &&
              (acc_q[$past(wr_idx)] == $past(wr_acc)) &&
              (mod_q[$past(wr_idx)] == $past(wr_mod)));

  // R2: with no update and no write, the table holds still
  a_r2_quiet_table: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en && !wr_en) |=> $stable(val_q) && $stable(acc_q) && $stable(mod_q) && $stable(page_q));
endmodule

// File: rtl/ipt_match.sv
module ipt_match #(
  parameter int unsigned FRAMES = 32,
  parameter int unsigned PAGE_W = 6,
  localparam int unsigned IDX_W = $clog2(FRAMES)
) (
  input  logic [PAGE_W-1:0]              vpage,
  input  logic [FRAMES-1:0]              val_vec,
  input  logic [FRAMES-1:0][PAGE_W-1:0]  page_vec,
  output logic                           hit,
  output logic [IDX_W-1:0]               hit_idx,
  output logic [FRAMES-1:0]              first_vec
);
  logic [FRAMES-1:0] eq_vec;

  for (genvar g = 0; g < FRAMES; g++) begin : g_cmp
    assign eq_vec[g] = val_vec[g] && (page_vec[g] == vpage);
  end

  // Lowest-numbered matching frame wins
  always_comb begin
    hit_idx   = '0;
    first_vec = '0;
    for (int i = int'(FRAMES) - 1; i >= 0; i--) begin
      if (eq_vec[i]) begin
        hit_idx   = IDX_W'(i);
        first_vec = FRAMES'(1) << i;
      end
    end
  end

  assign hit = |eq_vec;

  always_comb begin
    // R5: at most one frame is selected
    a_r5_single_winner: assert ($onehot0(first_vec));
    // R3 / R10: a hit names a valid entry holding the requested page
    a_r3_hit_is_real: assert (!hit || (val_vec[hit_idx] && page_vec[hit_idx] == vpage));
  end
endmodule

// File: rtl/ipt_mmu.sv
module ipt_mmu
  import ipt_pkg::*;
#(
  parameter int unsigned FRAMES = IPT_FRAMES,
  parameter int unsigned PAGE_W = IPT_PAGE_W,
  parameter int unsigned OFF_W  = IPT_OFF_W,
  localparam int unsigned IDX_W = $clog2(FRAMES),
  localparam int unsigned VA_W  = PAGE_W + OFF_W,
  localparam int unsigned PA_W  = IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vm_enable,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_hit,
  output logic              rsp_fault,
  input  logic              tbl_wr_en,
  input  logic [IDX_W-1:0]  tbl_wr_idx,
  input  logic              tbl_wr_valid,
  input  logic [PAGE_W-1:0] tbl_wr_page,
  input  logic              tbl_wr_accessed,
  input  logic              tbl_wr_modified,
  input  logic [IDX_W-1:0]  tbl_rd_idx,
  output logic              tbl_rd_valid,
  output logic [PAGE_W-1:0] tbl_rd_page,
  output logic              tbl_rd_accessed,
  output logic              tbl_rd_modified
);
  logic [FRAMES-1:0]             val_vec;
  logic [FRAMES-1:0][PAGE_W-1:0] page_vec;
  logic                          tbl_hit;
  logic [IDX_W-1:0]              tbl_idx;
  logic [FRAMES-1:0]             first_vec;
  logic                          xfer, upd_en;
  logic                          direct_ok;
  xl_kind_e                      kind;

  ipt_entry_store #(.FRAMES(FRAMES), .PAGE_W(PAGE_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (tbl_wr_en),
    .wr_idx   (tbl_wr_idx),
    .wr_valid (tbl_wr_valid),
    .wr_page  (tbl_wr_page),
    .wr_acc   (tbl_wr_accessed),
    .wr_mod   (tbl_wr_modified),
    .upd_en   (upd_en),
    .upd_idx  (tbl_idx),
    .upd_write(req_write),
    .rd_idx   (tbl_rd_idx),
    .rd_valid (tbl_rd_valid),
    .rd_page  (tbl_rd_page),
    .rd_acc   (tbl_rd_accessed),
    .rd_mod   (tbl_rd_modified),
    .val_vec  (val_vec),
    .page_vec (page_vec)
  );

  ipt_match #(.FRAMES(FRAMES), .PAGE_W(PAGE_W)) u_match (
    .vpage    (req_vaddr[VA_W-1:OFF_W]),
    .val_vec  (val_vec),
    .page_vec (page_vec),
    .hit      (tbl_hit),
    .hit_idx  (tbl_idx),
    .first_vec(first_vec)
  );

  // Direct access is legal only when the address fits in user space
  assign direct_ok = (req_vaddr >> PA_W) == '0;

  always_comb begin
    if (vm_enable) kind = tbl_hit ? XL_MAPPED : XL_FAULT;
    else           kind = direct_ok ? XL_DIRECT : XL_FAULT;
  end

  always_comb begin
    unique case (kind)
      XL_MAPPED: rsp_paddr = {tbl_idx, req_vaddr[OFF_W-1:0]};
      XL_DIRECT: rsp_paddr = req_vaddr[PA_W-1:0];
      default:   rsp_paddr = '0;
    endcase
  end

  assign rsp_hit   = (kind != XL_FAULT);
  assign rsp_fault = (kind == XL_FAULT);
  assign rsp_valid = req_valid;
  assign req_ready = rsp_ready;
  assign xfer      = req_valid && rsp_ready;
  assign upd_en    = xfer && (kind == XL_MAPPED);

  // R4: hit and fault are exclusive and a fault carries a zero address
  a_r4_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit != rsp_fault) && (!rsp_fault || rsp_paddr == '0));

  // R8: direct mode keeps in-range addresses unchanged
  a_r8_direct_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !vm_enable && req_vaddr[VA_W-1] == 1'b0) |-> (rsp_hit && rsp_paddr == req_vaddr[PA_W-1:0]));

  // R3: a mapped response keeps the word offset and uses the selected frame
  a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && vm_enable && rsp_hit) |->
      (rsp_paddr[OFF_W-1:0] == req_vaddr[OFF_W-1:0]) && first_vec[rsp_paddr[PA_W-1:OFF_W]]);
endmodule

// File: tb/ipt_mmu_tb.sv
`timescale 1ns/1ps
module ipt_mmu_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vm_enable = 1'b0, req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [10:0] req_vaddr = '0;
  logic req_ready, rsp_valid, rsp_hit, rsp_fault;
  logic [9:0] rsp_paddr;
  logic tbl_wr_en = 1'b0, tbl_wr_valid = 1'b0, tbl_wr_accessed = 1'b0, tbl_wr_modified = 1'b0;
  logic [4:0] tbl_wr_idx = '0, tbl_rd_idx = '0;
  logic [5:0] tbl_wr_page = '0;
  logic tbl_rd_valid, tbl_rd_accessed, tbl_rd_modified;
  logic [5:0] tbl_rd_page;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ipt_mmu u_dut (
    .clk(clk), .rst_n(rst_n), .vm_enable(vm_enable),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_valid(tbl_wr_valid),
    .tbl_wr_page(tbl_wr_page), .tbl_wr_accessed(tbl_wr_accessed), .tbl_wr_modified(tbl_wr_modified),
    .tbl_rd_idx(tbl_rd_idx), .tbl_rd_valid(tbl_rd_valid), .tbl_rd_page(tbl_rd_page),
    .tbl_rd_accessed(tbl_rd_accessed), .tbl_rd_modified(tbl_rd_modified)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [10:0] va(input int page, input int off);
    return {6'(page), 5'(off)};
  endfunction

  task automatic load(input int idx, input bit v, input int page, input bit a, input bit m);
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_wr_idx = 5'(idx); tbl_wr_valid = v;
    tbl_wr_page = 6'(page); tbl_wr_accessed = a; tbl_wr_modified = m;
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  // Present a request at a falling edge; response is combinational
  task automatic present(input logic [10:0] addr, input bit wr, input bit vm, input bit rdy);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = addr; req_write = wr; vm_enable = vm; rsp_ready = rdy;
    #1;
  endtask

  task automatic retire;
    @(negedge clk);
    req_valid = 1'b0; rsp_ready = 1'b1; req_write = 1'b0;
    #1;
  endtask

  task automatic peek(input int idx);
    tbl_rd_idx = 5'(idx);
    #1;
  endtask

  task automatic t_reset;
    peek(0);
    chk("R1 valid", tbl_rd_valid, 0);
    chk("R1 page", tbl_rd_page, 0);
    peek(31);
    chk("R1 accessed", tbl_rd_accessed, 0);
    chk("R1 modified", tbl_rd_modified, 0);
    present(va(0, 0), 1'b0, 1'b1, 1'b1);
    chk("R1 fault after reset", rsp_fault, 1);
    retire();
  endtask

  task automatic t_basic_hit;
    load(3, 1'b1, 10, 1'b0, 1'b0);
    present(va(10, 7), 1'b0, 1'b1, 1'b1);
    chk("R3 hit", rsp_hit, 1);
    chk("R3 paddr", rsp_paddr, 3 * 32 + 7);
    chk("R2 rsp_valid", rsp_valid, 1);
    chk("R2 req_ready", req_ready, 1);
    retire();
    peek(3);
    chk("R6 accessed after read hit", tbl_rd_accessed, 1);
    chk("R7 read keeps modified", tbl_rd_modified, 0);
    present(va(10, 31), 1'b1, 1'b1, 1'b1);
    chk("R3 paddr offset 31", rsp_paddr, 3 * 32 + 31);
    retire();
    peek(3);
    chk("R7 modified after write hit", tbl_rd_modified, 1);
  endtask

  task automatic t_miss;
    present(va(40, 4), 1'b1, 1'b1, 1'b1);
    chk("R4 fault", rsp_fault, 1);
    chk("R4 no hit", rsp_hit, 0);
    chk("R4 paddr zero", rsp_paddr, 0);
    retire();
  endtask

  task automatic t_invalid_entry;
    load(12, 1'b0, 30, 1'b0, 1'b0);
    present(va(30, 1), 1'b1, 1'b1, 1'b1);
    chk("R10 invalid entry faults", rsp_fault, 1);
    retire();
    peek(12);
    chk("R10 invalid entry untouched", tbl_rd_accessed, 0);
  endtask

  task automatic t_priority;
    load(9, 1'b1, 20, 1'b0, 1'b0);
    load(5, 1'b1, 20, 1'b0, 1'b0);
    present(va(20, 0), 1'b0, 1'b1, 1'b1);
    chk("R5 lowest frame", rsp_paddr, 5 * 32);
    retire();
    peek(9);
    chk("R5 shadowed entry not accessed", tbl_rd_accessed, 0);
    peek(5);
    chk("R5 winner accessed", tbl_rd_accessed, 1);
  endtask

  task automatic t_stall;
    load(7, 1'b1, 33, 1'b0, 1'b0);
    present(va(33, 2), 1'b1, 1'b1, 1'b0);
    chk("R2 ready follows consumer", req_ready, 0);
    chk("R2 response during stall", rsp_paddr, 7 * 32 + 2);
    retire();
    peek(7);
    chk("R2 stall no accessed", tbl_rd_accessed, 0);
    chk("R2 stall no modified", tbl_rd_modified, 0);
  endtask

  task automatic t_os_priority;
    // Software rewrites entry 7 in the cycle a store hits it
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va(33, 2); req_write = 1'b1; vm_enable = 1'b1; rsp_ready = 1'b1;
    tbl_wr_en = 1'b1; tbl_wr_idx = 5'd7; tbl_wr_valid = 1'b1; tbl_wr_page = 6'd34;
    tbl_wr_accessed = 1'b0; tbl_wr_modified = 1'b0;
    @(negedge clk);
    tbl_wr_en = 1'b0;
    req_valid = 1'b0; req_write = 1'b0;
    peek(7);
    chk("R9 page from software", tbl_rd_page, 34);
    chk("R9 accessed from software", tbl_rd_accessed, 0);
    chk("R9 modified from software", tbl_rd_modified, 0);
  endtask

  task automatic t_bypass;
    load(20, 1'b1, 5, 1'b0, 1'b0);
    present(va(5, 3), 1'b1, 1'b0, 1'b1);
    chk("R8 direct hit", rsp_hit, 1);
    chk("R8 direct paddr", rsp_paddr, 5 * 32 + 3);
    retire();
    peek(20);
    chk("R8 no table update", tbl_rd_accessed, 0);
    present(va(34, 2), 1'b0, 1'b0, 1'b1);
    chk("R8 out of range faults", rsp_fault, 1);
    chk("R8 out of range paddr", rsp_paddr, 0);
    retire();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic_hit();
    t_miss();
    t_invalid_entry();
    t_priority();
    t_stall();
    t_os_priority();
    t_bypass();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule